// File: doc/BRIEF.md
# Bit-Serial Line Scrambler and Self-Synchronizing Descrambler

This block whitens the bit stream of a subscriber line transceiver before symbol mapping and restores it on the receive side. It holds two independent lanes: a transmit scrambler and a receive descrambler. Each lane takes one bit per clock while its enable is high. Each lane keeps a 23-stage shift register. The output bit is the input bit summed modulo 2 with two taps of that register.

A shared mode input chooses the tap set. Line-termination mode uses the taps at delays 5 and 23. Network-termination mode uses the taps at delays 18 and 23. An external framer raises each lane's bypass input on the positions of the framing pattern. Those bits cross the lane unchanged and leave the register untouched.

The scrambler shifts its own output into the register. The descrambler shifts the received line bit into its register. Because of that, the descrambler aligns itself to any scrambler with the same tap set. After 23 scrambled (non-bypass) bits it delivers the original data, whatever state it started in.

Top module: `line_scrambler`

## Requirements
- R1: While rst_n is low, both shift registers clear to zero and both output bits drive 0. After reset, the first scrambled bits therefore leave equal to their inputs until a 1 reaches a tap.
- R2: With mode = 0 (line termination), an enabled non-bypass transmit bit produces tx_out = tx_bit XOR s5 XOR s23. Here sk is the k-th most recent bit that the transmit lane shifted in, and that bit is its own output.
- R3: With mode = 1 (network termination), the same rule applies with taps s18 and s23 in place of s5 and s23.
- R4: A bit presented with its lane's bypass high and enable high leaves the lane unchanged on the output. It does not shift the register, so the next scrambled bit sees the same taps it would have seen had the bypass bit never come.
- R5: While a lane's enable is low, its output and its shift register hold their values.
- R6: An enabled non-bypass receive bit produces rx_out = rx_bit XOR r5 XOR r23 in mode 0, or rx_bit XOR r18 XOR r23 in mode 1. Here rk is the k-th most recent non-bypass received bit.
- R7: When the transmit output feeds the receive input with the same mode and bypass pattern, rx_out equals the original tx_bit for every bit after the descrambler has taken 23 non-bypass bits. This holds from any starting state.
- R8: Each output is registered. It changes on the rising clock edge that accepts the enabled input and stays put until that edge.
- R9: The mode is applied bit by bit, so changing mode between two bits changes the taps used for the next bit. The register contents do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode | input | 1 | Tap set: 0 = line termination (5, 23), 1 = network termination (18, 23) |
| tx_en | input | 1 | Transmit bit strobe |
| tx_bypass | input | 1 | Transmit bit is a framing position |
| tx_bit | input | 1 | Transmit data bit |
| tx_out | output | 1 | Scrambled transmit bit, registered |
| rx_en | input | 1 | Receive bit strobe |
| rx_bypass | input | 1 | Receive bit is a framing position |
| rx_bit | input | 1 | Received line bit |
| rx_out | output | 1 | Descrambled receive bit, registered |

## Verification
The bench runs long random streams in each mode against a 23-bit history model. Bypass and idle bits are mixed in, so a lane that shifted during a framing position, or on a low enable, leaves the model's taps from that point on. Swapping the 5 and 18 taps between modes, or feeding the scrambler with its input instead of its output, shows up within a few dozen bits. A loopback run starts the descrambler from a deliberately dirty state and expects exact data after 23 scrambled bits. A descrambler that shifted its own output in would never recover. The bench also switches mode on every bit and samples each output just before the edge, which catches a combinational output or a latched mode.

// File: rtl/line_scrambler_pkg.sv
// Shared constants and types for the line scrambler.
// Assumes the two tap sets share the longest delay (the register length).
package line_scrambler_pkg;

    localparam int STAGES = 23;   // shift register length, also the common long tap
    localparam int TAP_LT = 5;    // short tap in line-termination mode
    localparam int TAP_NT = 18;   // short tap in network-termination mode

    typedef enum logic {
        MODE_LT = 1'b0,
        MODE_NT = 1'b1
    } line_mode_e;

endpackage

// File: rtl/scr_tap_sel.sv
// Feedback selector: forms the modulo-2 sum of the short tap chosen by the
// mode and the long tap at the end of the register.
// Assumes state[0] holds the most recent bit (delay 1), state[k-1] delay k.
module scr_tap_sel
    import line_scrambler_pkg::*;
#(
    parameter int N      = STAGES,
    parameter int TAP_A  = TAP_LT,
    parameter int TAP_B  = TAP_NT
) (
    input  logic [N-1:0] state,
    input  line_mode_e   mode,
    output logic         fb
);

    localparam int IDX_A = TAP_A - 1;
    localparam int IDX_B = TAP_B - 1;
    localparam int IDX_L = N - 1;

    logic short_tap;

    // Pick the mode-dependent short tap.
    always_comb begin
        short_tap = (mode == MODE_NT) ? state[IDX_B] : state[IDX_A];
    end

    // Sum the short tap with the common long tap.
    always_comb begin
        fb = short_tap ^ state[IDX_L];
    end

endmodule

// File: rtl/scr_lane.sv
// One scrambling lane. With SELF_SYNC = 0 it scrambles: the output bit is
// shifted into the register. With SELF_SYNC = 1 it descrambles: the incoming
// line bit is shifted in. Bypass bits pass unchanged and do not shift; a low
// enable freezes both the register and the registered output.
// Assumes en, bypass and din are synchronous to clk.
module scr_lane
    import line_scrambler_pkg::*;
#(
    parameter int N         = STAGES,
    parameter int TAP_A     = TAP_LT,
    parameter int TAP_B     = TAP_NT,
    parameter bit SELF_SYNC = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  line_mode_e   mode,
    input  logic         en,
    input  logic         bypass,
    input  logic         din,
    output logic         dout,
    output logic [N-1:0] state_o
);

    logic [N-1:0] state_q;
    logic         fb;
    logic         coded;
    logic         shift_bit;

    scr_tap_sel #(
        .N     (N),
        .TAP_A (TAP_A),
        .TAP_B (TAP_B)
    ) tap_i (
        .state (state_q),
        .mode  (mode),
        .fb    (fb)
    );

    // Code the current bit, or let a framing bit through.
    always_comb begin
        coded = bypass ? din : (din ^ fb);
    end

    // Choose what enters the register: own output or the line bit.
    generate
        if (SELF_SYNC) begin : g_descr
            always_comb shift_bit = din;
        end else begin : g_scr
            always_comb shift_bit = coded;
        end
    endgenerate

    // Advance the history only on enabled, non-framing bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else if (en && !bypass) begin
            state_q <= {state_q[N-2:0], shift_bit};
        end
    end

    // Register the coded bit on every enabled bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout <= 1'b0;
        end else if (en) begin
            dout <= coded;
        end
    end

    assign state_o = state_q;

endmodule

// File: rtl/line_scrambler.sv
// Top of the line scrambler: a transmit scrambler and a receive descrambler
// sharing one tap-set mode input.
// Assumes the framer drives each bypass on framing-pattern positions only.
module line_scrambler
    import line_scrambler_pkg::*;
#(
    parameter int N     = STAGES,
    parameter int TAP_A = TAP_LT,
    parameter int TAP_B = TAP_NT
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mode,
    input  logic tx_en,
    input  logic tx_bypass,
    input  logic tx_bit,
    output logic tx_out,
    input  logic rx_en,
    input  logic rx_bypass,
    input  logic rx_bit,
    output logic rx_out
);

    line_mode_e   mode_e;
    logic [N-1:0] tx_state;
    logic [N-1:0] rx_state;

    // Map the mode pin onto the enum.
    always_comb begin
        mode_e = line_mode_e'(mode);
    end

    scr_lane #(
        .N         (N),
        .TAP_A     (TAP_A),
        .TAP_B     (TAP_B),
        .SELF_SYNC (1'b0)
    ) tx_lane_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (mode_e),
        .en      (tx_en),
        .bypass  (tx_bypass),
        .din     (tx_bit),
        .dout    (tx_out),
        .state_o (tx_state)
    );

    scr_lane #(
        .N         (N),
        .TAP_A     (TAP_A),
        .TAP_B     (TAP_B),
        .SELF_SYNC (1'b1)
    ) rx_lane_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (mode_e),
        .en      (rx_en),
        .bypass  (rx_bypass),
        .din     (rx_bit),
        .dout    (rx_out),
        .state_o (rx_state)
    );

endmodule

// File: rtl/line_scrambler_chk.sv
// Assertion checker for line_scrambler, bound to every instance of it.
// Assumes it sees the lane histories through the top's internal signals.
module line_scrambler_chk #(
    parameter int N = 23
) (
    input logic         clk,
    input logic         rst_n,
    input logic         tx_en,
    input logic         tx_bypass,
    input logic         tx_bit,
    input logic         tx_out,
    input logic         rx_en,
    input logic         rx_bypass,
    input logic         rx_bit,
    input logic         rx_out,
    input logic [N-1:0] tx_state,
    input logic [N-1:0] rx_state
);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (tx_state == '0 && rx_state == '0 && !tx_out && !rx_out));

    // R4
    tx_bypass_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && tx_bypass) |=> (tx_out == $past(tx_bit)));

    // R4
    rx_bypass_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && rx_bypass) |=> (rx_out == $past(rx_bit)));

    // R4
    tx_bypass_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && tx_bypass) |=> $stable(tx_state));

    // R5
    tx_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> ($stable(tx_out) && $stable(tx_state)));

    // R5
    rx_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> ($stable(rx_out) && $stable(rx_state)));

    // R2
    tx_feeds_own_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && !tx_bypass) |=> (tx_state[0] == tx_out));

    // R6
    rx_feeds_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && !rx_bypass) |=> (rx_state[0] == $past(rx_bit)));

endmodule

bind line_scrambler line_scrambler_chk #(.N(N)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_en     (tx_en),
    .tx_bypass (tx_bypass),
    .tx_bit    (tx_bit),
    .tx_out    (tx_out),
    .rx_en     (rx_en),
    .rx_bypass (rx_bypass),
    .rx_bit    (rx_bit),
    .rx_out    (rx_out),
    .tx_state  (tx_state),
    .rx_state  (rx_state)
);

// File: tb/line_scrambler_tb_top.sv
// Self-checking bench: random sweeps against a history model, mode switching,
// and a loopback recovery run from a dirty descrambler state.
module line_scrambler_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NST        = 23;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode = 1'b0;
    logic tx_en = 1'b0, tx_bypass = 1'b0, tx_bit = 1'b0;
    logic rx_en = 1'b0, rx_bypass = 1'b0, rx_bit = 1'b0;
    logic tx_out, rx_out;

    int checks = 0;
    int errors = 0;
    logic [NST-1:0] mt = '0;
    logic [NST-1:0] mr = '0;
    logic exp_tx = 1'b0;
    logic exp_rx = 1'b0;
    logic data_mem [0:199];
    logic line_mem [0:199];
    logic byp_mem  [0:199];

    always #(CLK_PERIOD/2) clk = ~clk;

    line_scrambler dut_i (
        .clk(clk), .rst_n(rst_n), .mode(mode),
        .tx_en(tx_en), .tx_bypass(tx_bypass), .tx_bit(tx_bit), .tx_out(tx_out),
        .rx_en(rx_en), .rx_bypass(rx_bypass), .rx_bit(rx_bit), .rx_out(rx_out)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    function automatic logic taps(input logic [NST-1:0] h, input logic m);
        return (m ? h[17] : h[4]) ^ h[22];
    endfunction

    // One bit on both lanes; the model predicts the edge that accepts it.
    task automatic step(input logic m, input logic te, input logic tb, input logic td,
                        input logic re, input logic rb, input logic rd,
                        input string ttag, input string rtag);
        @(negedge clk);
        mode = m; tx_en = te; tx_bypass = tb; tx_bit = td;
        rx_en = re; rx_bypass = rb; rx_bit = rd;
        #1;
        // R8: nothing moves before the edge
        check("R8 tx", tx_out, exp_tx);
        check("R8 rx", rx_out, exp_rx);
        if (te) begin
            exp_tx = tb ? td : (td ^ taps(mt, m));
            if (!tb) mt = {mt[NST-2:0], exp_tx};
        end
        if (re) begin
            exp_rx = rb ? rd : (rd ^ taps(mr, m));
            if (!rb) mr = {mr[NST-2:0], rd};
        end
        @(posedge clk);
        #1;
        check(ttag, tx_out, exp_tx);
        check(rtag, rx_out, exp_rx);
    endtask

    task automatic rand_phase(input int n, input int m_sel);
        for (int i = 0; i < n; i++) begin
            logic m, te, tb, re, rb;
            string tt, rt;
            m  = (m_sel == 2) ? 1'($urandom_range(0, 1)) : 1'(m_sel);
            te = ($urandom_range(0, 99) < 85);
            tb = ($urandom_range(0, 99) < 15);
            re = ($urandom_range(0, 99) < 85);
            rb = ($urandom_range(0, 99) < 15);
            tt = !te ? "R5 tx" : tb ? "R4 tx" : (m_sel == 2) ? "R9 tx" : m ? "R3" : "R2";
            rt = !re ? "R5 rx" : rb ? "R4 rx" : (m_sel == 2) ? "R9 rx" : "R6";
            step(m, te, tb, 1'($urandom_range(0, 1)), re, rb, 1'($urandom_range(0, 1)), tt, rt);
        end
    endtask

    // R7: scramble a block, then descramble it starting from a dirty state.
    task automatic loopback(input logic m);
        int seen;
        for (int i = 0; i < 40; i++)
            step(m, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'($urandom_range(0, 1)), "R5 tx", "R6");
        for (int i = 0; i < 200; i++) begin
            data_mem[i] = 1'($urandom_range(0, 1));
            byp_mem[i]  = ($urandom_range(0, 99) < 10);
            step(m, 1'b1, byp_mem[i], data_mem[i], 1'b0, 1'b0, 1'b0,
                 m ? "R3" : "R2", "R5 rx");
            line_mem[i] = tx_out;
        end
        seen = 0;
        for (int i = 0; i < 200; i++) begin
            step(m, 1'b0, 1'b0, 1'b0, 1'b1, byp_mem[i], line_mem[i], "R5 tx", "R6");
            if (seen >= NST) check("R7 loopback", rx_out, data_mem[i]);
            if (!byp_mem[i]) seen++;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: cleared outputs under reset
        check("R1 tx", tx_out, 1'b0);
        check("R1 rx", rx_out, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: zero history means the first bits leave unchanged
        for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, "R1 tx", "R1 rx");
        rand_phase(800, 0);
        rand_phase(800, 1);
        rand_phase(600, 2);
        loopback(1'b0);
        loopback(1'b1);
        finish_run();
    end

endmodule